// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block gathers up to 32 interrupt inputs and presents them to a host processor as one active-high request line. The host configures it through a simple word-addressed register port. Each source has three pieces of state: a mode word holding its trigger type and priority, a vector word, and an enable bit. Enable bits are never written directly. The host sets them with a write-one command word, clears them with a second write-one command word, and reads all of them back through a mask word.

To take an interrupt, the handler reads the vector word. It gets the vector of the strongest pending, enabled source. If nothing qualifies, it gets the value held in a programmable spurious-vector word. A successful vector read pushes the winner's priority onto an internal nesting stack and retires that source's edge latch. From then on, only sources of strictly higher priority raise the request line. A write to the end-of-service word pops one level; the data written is ignored. The stack is eight levels deep.

Sources marked external by a parameter support all four trigger types. Internal sources fold the low-level type into high-level and the falling-edge type into rising-edge.

Top module: `icu_vectored`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every register. After reset, irq is low, the enable mask reads 0, the spurious word reads 0 and every mode word reads 0.
- R2: A write to address 0x81 sets the enable bit of every source whose data bit is 1. Bits written as 0 leave their enable bits unchanged. The enable mask is read at address 0x83.
- R3: A write to address 0x82 clears the enable bit of every source whose data bit is 1. Bits written as 0 leave their enable bits unchanged.
- R4: The mode word of source i is at address i. Its bits [5:4] hold the trigger type: 00 high level, 01 low level, 10 rising edge, 11 falling edge. Its bits [2:0] hold the priority, where 7 is strongest. A level-type source is pending exactly while its input is at the active level.
- R5: An edge-type source latches pending on the selected edge and stays pending after the input returns. The latch clears when that source wins a vector read (address 0x80).
- R6: Sources 28 to 31 are external. For every other source, type 01 behaves as type 00 and type 11 behaves as type 10.
- R7: The vector word of source i is at address 0x40+i. A vector read returns the vector of the pending, enabled source with the highest priority that is above the current nesting level. Ties go to the lower source number.
- R8: A vector read with no qualifying source returns the spurious word (address 0x85). It leaves the nesting stack unchanged.
- R9: A write to address 0x84 clears the edge latch of every source whose data bit is 1. An edge arriving in the same cycle as that write wins, and the latch stays set.
- R10: A winning vector read pushes the winner's priority onto the stack. irq is high, one cycle after the condition, exactly when a qualifying source exists. With a non-empty stack, a source qualifies only if its priority is strictly greater than the top entry.
- R11: A write to address 0x86 pops one level, and its data is ignored. The stack holds 8 levels. With 8 levels held, irq stays low and a vector read returns the spurious word. Eight pops release the request again.
- R12: Read data appears on rdata in the cycle after rd_en and holds otherwise. When wr_en and rd_en are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Interrupt source inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Active-high interrupt request to the processor |

## Verification
An edge on a source's input and a pending-clear command naming that same source can land on the same clock edge. The bench provokes this by raising the input on the same falling edge that drives the clear write. It judges the result by a later vector read, which must still return that source's vector. A register write and a read can also be strobed in the same cycle. The bench checks that rdata keeps its previous value while the write to the spurious word takes effect.

// File: rtl/icu_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes an 8-bit word address space. Per-source words sit in the low
// half of that space, and control words sit at 0x80 and above.
package icu_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_VECTOR   = 8'h80;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h81;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h82;
    localparam logic [ADDR_W-1:0] A_EN_MASK  = 8'h83;
    localparam logic [ADDR_W-1:0] A_PEND_CLR = 8'h84;
    localparam logic [ADDR_W-1:0] A_SPUR     = 8'h85;
    localparam logic [ADDR_W-1:0] A_EOI      = 8'h86;

endpackage

// File: rtl/icu_trigger.sv
// Per-source trigger conditioning.
// Turns raw inputs into pending flags according to each source's trigger
// type. Level types pass the input straight through, after any polarity
// inversion. Edge types set a latch, which clr_mask clears. A new edge
// wins over a clear in the same cycle. Inversion applies only to sources
// flagged in EXT_MASK. Inputs are assumed synchronous to clk.
module icu_trigger #(
    parameter int                  NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0]  EXT_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [2*NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0]   clr_mask,
    output logic [NUM_SRC-1:0]   pend
);
    import icu_pkg::*;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        trig_e mode;
        logic  is_edge;
        logic  invert;
        logic  act;
        logic  act_d;
        logic  latch_q;

        assign mode    = trig_e'(trig[2*i +: 2]);
        assign is_edge = (mode == TRIG_RISE) || (mode == TRIG_FALL);
        assign invert  = ((mode == TRIG_LOW) || (mode == TRIG_FALL)) && EXT_MASK[i];
        assign act     = src_in[i] ^ invert;

        // Track the previous active level and hold the edge latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_d   <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                act_d <= act;
                if (is_edge && act && !act_d) begin
                    latch_q <= 1'b1;
                end else if (clr_mask[i]) begin
                    latch_q <= 1'b0;
                end
            end
        end

        assign pend[i] = is_edge ? latch_q : act;
    end

endmodule

// File: rtl/icu_arbiter.sv
// Combinational winner selection.
// Picks the eligible source with the highest priority that beats the
// current nesting level. When the level is not valid (the stack is
// empty), any eligible source qualifies. Ties go to the lowest index.
// A full stack blocks every source.
module icu_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         level,
    input  logic                      level_valid,
    input  logic                      blocked,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);

    // Scan from the top index down so that '>=' keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && !blocked
                && (!level_valid || prio[i*PRIO_W +: PRIO_W] > level)
                && (!found || prio[i*PRIO_W +: PRIO_W] >= win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/icu_stack.sv
// Nesting-level stack of priorities.
// A push stores a value unless the stack is full. A pop drops the top
// entry unless the stack is empty. Push takes precedence if both are
// requested, although the top level never requests both.
module icu_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_val,
    output logic [PRIO_W-1:0] top,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  top_ptr;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign top_ptr = cnt - 1'b1;
    assign top     = mem[top_ptr[PTR_W-1:0]];
    assign count   = cnt;

    // Update storage and occupancy on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !full) begin
            mem[cnt[PTR_W-1:0]] <= push_val;
            cnt                 <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/icu_vectored.sv
// Nested vectored interrupt controller, top level.
// Holds the per-source mode and vector words, the enable mask and the
// spurious word. It decodes the register port, answers vector reads with
// the arbiter's winner and drives a registered request line. It assumes
// NUM_SRC <= 32 and NUM_SRC <= DATA_W, that VEC_W <= DATA_W and PRIO_W <= 4.
module icu_vectored #(
    parameter int                 NUM_SRC  = 32,
    parameter int                 PRIO_W   = 3,
    parameter int                 VEC_W    = 8,
    parameter int                 DEPTH    = 8,
    parameter int                 DATA_W   = 32,
    parameter logic [NUM_SRC-1:0] EXT_MASK = {4'hF, {(NUM_SRC-4){1'b0}}}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          src_in,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [icu_pkg::ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        irq
);
    import icu_pkg::*;

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [2*NUM_SRC-1:0]      trig_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [VEC_W-1:0]          vec_q [NUM_SRC];
    logic [NUM_SRC-1:0]        en_q;
    logic [VEC_W-1:0]          spur_q;
    logic                      irq_q;

    logic [IDX_W-1:0]   idx;
    logic               mode_sel, vec_sel, rd_act, vec_read, ack, eoi;
    logic [NUM_SRC-1:0] pend, clr_mask, wmask;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio, stk_top;
    logic               stk_empty, stk_full;
    logic [CNT_W-1:0]   stk_cnt;
    logic [DATA_W-1:0]  rd_word;

    assign idx      = addr[IDX_W-1:0];
    assign mode_sel = (addr[7:6] == 2'b00) && (addr[5:0] < 6'(NUM_SRC));
    assign vec_sel  = (addr[7:6] == 2'b01) && (addr[5:0] < 6'(NUM_SRC));
    assign rd_act   = rd_en && !wr_en;
    assign vec_read = rd_act && (addr == A_VECTOR);
    assign ack      = vec_read && found;
    assign eoi      = wr_en && (addr == A_EOI);
    assign wmask    = wdata[NUM_SRC-1:0];

    // Retire the winner's edge latch on acknowledge, plus any commanded clears.
    assign clr_mask = ((wr_en && addr == A_PEND_CLR) ? wmask : '0)
                    | (ack ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << win_idx) : '0);

    icu_trigger #(.NUM_SRC(NUM_SRC), .EXT_MASK(EXT_MASK)) u_trigger (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .trig     (trig_q),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    icu_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arbiter (
        .elig        (pend & en_q),
        .prio        (prio_q),
        .level       (stk_top),
        .level_valid (!stk_empty),
        .blocked     (stk_full),
        .found       (found),
        .win_idx     (win_idx),
        .win_prio    (win_prio)
    );

    icu_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack),
        .pop      (eoi),
        .push_val (win_prio),
        .top      (stk_top),
        .empty    (stk_empty),
        .full     (stk_full),
        .count    (stk_cnt)
    );

    // Configuration and enable registers, written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            prio_q <= '0;
            en_q   <= '0;
            spur_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) vec_q[i] <= '0;
        end else if (wr_en) begin
            if (mode_sel) begin
                trig_q[2*idx +: 2]           <= wdata[5:4];
                prio_q[idx*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
            end
            if (vec_sel)             vec_q[idx] <= wdata[VEC_W-1:0];
            if (addr == A_EN_SET)    en_q       <= en_q | wmask;
            if (addr == A_EN_CLR)    en_q       <= en_q & ~wmask;
            if (addr == A_SPUR)      spur_q     <= wdata[VEC_W-1:0];
        end
    end

    // Read multiplexer for the addressed word.
    always_comb begin
        rd_word = '0;
        if (mode_sel) begin
            rd_word[5:4]        = trig_q[2*idx +: 2];
            rd_word[PRIO_W-1:0] = prio_q[idx*PRIO_W +: PRIO_W];
        end else if (vec_sel) begin
            rd_word[VEC_W-1:0] = vec_q[idx];
        end else begin
            case (addr)
                A_VECTOR:  rd_word[VEC_W-1:0]   = found ? vec_q[win_idx] : spur_q;
                A_EN_MASK: rd_word[NUM_SRC-1:0] = en_q;
                A_SPUR:    rd_word[VEC_W-1:0]   = spur_q;
                default:   rd_word              = '0;
            endcase
        end
    end

    // Register read data and the request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            irq_q <= 1'b0;
        end else begin
            if (rd_act) rdata <= rd_word;
            irq_q <= found;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/icu_vectored_sva.sv
// Property checker for icu_vectored. It observes the register port, the
// request line, the enable mask and the nesting stack occupancy.
module icu_vectored_sva #(
    parameter int NUM_SRC = 32,
    parameter int VEC_W   = 8,
    parameter int DEPTH   = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [icu_pkg::ADDR_W-1:0] addr,
    input logic [NUM_SRC-1:0]         wmask,
    input logic [VEC_W-1:0]           rdata_vec,
    input logic                       irq,
    input logic [NUM_SRC-1:0]         en_q,
    input logic [VEC_W-1:0]           spur_q,
    input logic [CNT_W-1:0]           stk_cnt,
    input logic                       stk_full,
    input logic                       found
);
    import icu_pkg::*;

    p_irq_low_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !irq);

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EN_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EN_CLR) |=> ((en_q & $past(wmask)) == '0));

    p_spur_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == A_VECTOR && !found)
        |=> (rdata_vec == $past(spur_q)) && (stk_cnt == $past(stk_cnt)));

    p_push_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == A_VECTOR && found)
        |=> stk_cnt == $past(stk_cnt) + CNT_W'(1));

    p_pop_on_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EOI && stk_cnt != '0)
        |=> stk_cnt == $past(stk_cnt) - CNT_W'(1));

    p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= CNT_W'(DEPTH));

    p_full_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> !irq);

endmodule

bind icu_vectored icu_vectored_sva #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .DEPTH   (DEPTH)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wmask     (wdata[NUM_SRC-1:0]),
    .rdata_vec (rdata[VEC_W-1:0]),
    .irq       (irq),
    .en_q      (en_q),
    .spur_q    (spur_q),
    .stk_cnt   (stk_cnt),
    .stk_full  (stk_full),
    .found     (found)
);

// File: tb/icu_vectored_test.sv
`timescale 1ns/1ps
// Self-checking bench for icu_vectored. It mixes seeded random stimulus
// with directed corner cases and compares against values the bench
// computes itself.
module icu_vectored_test;
    import icu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [2:0]  pr [32];
    logic [31:0] en_model;
    logic [31:0] d;

    icu_vectored uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic set_mode(input int s, input logic [1:0] t, input logic [2:0] p);
        wr(8'(s), {26'd0, t, 1'b0, p});
    endtask

    task automatic en_only(input logic [31:0] m);
        wr(A_EN_CLR, 32'hFFFF_FFFF);
        wr(A_EN_SET, m);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Expected winner: highest priority, lowest index on ties; -1 if none.
    function automatic int best(input logic [31:0] el);
        int w = -1;
        for (int i = 0; i < 32; i++)
            if (el[i] && (w < 0 || pr[i] > pr[w])) w = i;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(A_EN_MASK, d); chk("R1 mask", d, 32'd0);
        rd(A_SPUR, d);    chk("R1 spurious", d, 32'd0);
        rd(8'd17, d);     chk("R1 mode", d, 32'd0);

        // R2 / R3 random enable set and clear commands
        en_model = '0;
        for (int it = 0; it < 80; it++) begin
            logic [31:0] m = $urandom;
            if ($urandom_range(0, 1) == 1) begin
                wr(A_EN_SET, m); en_model |= m;
                rd(A_EN_MASK, d); chk("R2 enable set", d, en_model);
            end else begin
                wr(A_EN_CLR, m); en_model &= ~m;
                rd(A_EN_MASK, d); chk("R3 enable clear", d, en_model);
            end
        end

        for (int s = 0; s < 32; s++) wr(8'h40 + 8'(s), 32'h20 + 32'(s));
        wr(A_SPUR, 32'hEE);
        rd(A_SPUR, d); chk("R8 spurious word", d, 32'hEE);

        // R7 / R10 random arbitration on level-high sources
        for (int it = 0; it < 40; it++) begin
            logic [31:0] m   = $urandom;
            logic [31:0] inp = $urandom;
            int w;
            int k = $urandom_range(0, 31);
            for (int s = 0; s < 32; s++) begin
                pr[s] = 3'($urandom_range(0, 7));
                set_mode(s, TRIG_HIGH, pr[s]);
            end
            rd(8'(k), d); chk("R4 mode fields", d, {29'd0, pr[k]});
            src_in = inp;
            en_only(m);
            settle();
            w = best(inp & m);
            chk("R10 irq when eligible", {31'd0, irq}, {31'd0, w >= 0});
            rd(A_VECTOR, d);
            chk("R7 winning vector", d, (w >= 0) ? 32'h20 + 32'(w) : 32'hEE);
            if (w >= 0) wr(A_EOI, $urandom);
        end

        // R7 tie goes to the lower index
        src_in = '0;
        set_mode(3, TRIG_HIGH, 3'd5); set_mode(9, TRIG_HIGH, 3'd5);
        src_in[3] = 1'b1; src_in[9] = 1'b1;
        en_only(32'h0000_0208);
        settle();
        rd(A_VECTOR, d); chk("R7 tie", d, 32'h23);
        wr(A_EOI, 0);

        // R4 low level on external source 30
        src_in = '0;
        en_only(0);
        set_mode(30, TRIG_LOW, 3'd2);
        en_only(32'h4000_0000);
        settle();
        chk("R4 low level active", {31'd0, irq}, 32'd1);
        rd(A_VECTOR, d); chk("R4 low level vector", d, 32'h3E);
        wr(A_EOI, 0);
        src_in[30] = 1'b1;
        settle();
        chk("R4 low level inactive", {31'd0, irq}, 32'd0);

        // R6 internal source 5: low-level type acts as high level
        set_mode(5, TRIG_LOW, 3'd1);
        en_only(32'h0000_0020);
        src_in[5] = 1'b1; settle();
        chk("R6 internal low as high (1)", {31'd0, irq}, 32'd1);
        src_in[5] = 1'b0; settle();
        chk("R6 internal low as high (0)", {31'd0, irq}, 32'd0);

        // R6 internal source 6: falling type acts as rising
        set_mode(6, TRIG_FALL, 3'd1);
        wr(A_PEND_CLR, 32'h0000_0040);
        en_only(32'h0000_0040);
        src_in[6] = 1'b1; settle();
        chk("R6 internal fall as rise", {31'd0, irq}, 32'd1);
        rd(A_VECTOR, d); chk("R6 internal vector", d, 32'h26);
        wr(A_EOI, 0);
        src_in[6] = 1'b0; settle();
        rd(A_VECTOR, d); chk("R6 internal falling ignored", d, 32'hEE);

        // R5 rising edge on external source 28
        set_mode(28, TRIG_RISE, 3'd4);
        wr(A_PEND_CLR, 32'h1000_0000);
        en_only(32'h1000_0000);
        @(negedge clk) src_in[28] = 1'b1;
        @(negedge clk) src_in[28] = 1'b0;
        settle();
        chk("R5 edge latched", {31'd0, irq}, 32'd1);
        rd(A_VECTOR, d); chk("R5 edge vector", d, 32'h3C);
        wr(A_EOI, 0);
        settle();
        chk("R5 latch cleared by read", {31'd0, irq}, 32'd0);

        // R5 falling edge on external source 29
        src_in[29] = 1'b1;
        set_mode(29, TRIG_FALL, 3'd4);
        wr(A_PEND_CLR, 32'h2000_0000);
        en_only(32'h2000_0000);
        @(negedge clk) src_in[29] = 1'b0;
        @(negedge clk) src_in[29] = 1'b1;
        settle();
        rd(A_VECTOR, d); chk("R5 falling edge vector", d, 32'h3D);
        wr(A_EOI, 0);

        // R9 clear command, then edge and clear in the same cycle
        en_only(32'h1000_0000);
        @(negedge clk) src_in[28] = 1'b1;
        @(negedge clk) src_in[28] = 1'b0;
        wr(A_PEND_CLR, 32'h1000_0000);
        settle();
        chk("R9 cleared irq", {31'd0, irq}, 32'd0);
        rd(A_VECTOR, d); chk("R9 cleared vector", d, 32'hEE);
        @(negedge clk);
        src_in[28] = 1'b1; wr_en = 1'b1; addr = A_PEND_CLR; wdata = 32'h1000_0000;
        @(negedge clk);
        wr_en = 1'b0; src_in[28] = 1'b0;
        settle();
        rd(A_VECTOR, d); chk("R9 edge wins over clear", d, 32'h3C);
        wr(A_EOI, 0);

        // R10 / R11 nesting with level sources 0..7 at priority 0..7
        en_only(0);
        src_in = 32'h0000_10FF;
        for (int s = 0; s < 8; s++) set_mode(s, TRIG_HIGH, 3'(s));
        set_mode(12, TRIG_HIGH, 3'd3);
        for (int p = 0; p < 8; p++) begin
            wr(A_EN_SET, 32'd1 << p);
            settle();
            chk("R10 higher level raises irq", {31'd0, irq}, 32'd1);
            rd(A_VECTOR, d); chk("R10 nested vector", d, 32'h20 + 32'(p));
            if (p == 3) begin
                wr(A_EN_SET, 32'h0000_1000);
                settle();
                chk("R10 equal level held off", {31'd0, irq}, 32'd0);
                wr(A_EN_CLR, 32'h0000_1000);
            end
        end
        settle();
        chk("R11 full stack quiet", {31'd0, irq}, 32'd0);
        rd(A_VECTOR, d); chk("R11 full stack spurious", d, 32'hEE);
        en_only(0);
        for (int k = 0; k < 7; k++) wr(A_EOI, $urandom);
        wr(A_EN_SET, 32'd1);
        settle();
        chk("R11 one level left", {31'd0, irq}, 32'd0);
        wr(A_EOI, $urandom);
        settle();
        chk("R11 eighth pop releases", {31'd0, irq}, 32'd1);
        rd(A_VECTOR, d); chk("R11 vector after unwind", d, 32'h20);
        wr(A_EOI, 0);

        // R12 write and read strobed together
        rd(A_EN_MASK, d); chk("R12 read latency", d, 32'd1);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = A_SPUR; wdata = 32'h55;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12 read ignored", rdata, 32'd1);
        rd(A_SPUR, d); chk("R12 write taken", d, 32'h55);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule